// File: doc/BRIEF.md
# Counter-Assisted Stream Cipher Keystream Core

This block is a fully unrolled keystream generator. Its secret state is 513 bits wide: eight 32-bit state words, eight 32-bit counters and a single stored carry bit. In one clock cycle it performs a whole iteration. The counters advance through a 256-bit chained-carry adder that uses fixed per-word constants. Each state word then passes through a squaring-based nonlinear function g. Every new word is a sum of three g outputs, rotated according to the parity of the word index. A 128-bit keystream block is taken from the state words.

Setup is done in hardware. A key, an optional IV and an IV-enable flag are accepted over a valid/ready load handshake, and a start pulse begins setup. Setup runs in this order:
- key expansion;
- four warm-up iterations;
- a counter re-mix with the state;
- when the IV is enabled, an IV injection and four more iterations;
- one last iteration that produces the first block.

Keystream blocks are then offered on a valid/ready output. An accepted load while blocks are being delivered abandons the stream and restarts setup with the new material.

The controller has eight named states:
- IDLE: waits for a start pulse and goes to EXPAND.
- EXPAND: loads the state from the key and goes to WARM.
- WARM: runs four iterations and goes to KEYMIX.
- KEYMIX: re-mixes the counters. It goes to IVMIX when the IV is enabled, otherwise to PRIME.
- IVMIX: injects the IV and goes to IVWARM.
- IVWARM: runs four iterations and goes to PRIME.
- PRIME: runs one iteration and goes to RUN.
- RUN: advances on each accepted block. It goes back to EXPAND on an accepted load.

Top module: `kscore_top`

## Requirements
- R1: After reset the core is idle: `ks_valid_o`=0, `busy_o`=0, `load_ready_o`=1.
- R2: A load is accepted only when `load_valid_i` and `load_ready_o` are both high, and `load_ready_o` is low whenever `busy_o` is high. A start pulse in idle begins setup, which keeps `busy_o` high for 7 cycles without IV and 12 cycles with IV. A load offered while busy changes nothing.
- R3: Key expansion uses 16-bit subkeys, with k0 = key[15:0]. For even j: x_j = k_{j+1}||k_j and c_j = k_{j+4}||k_{j+5}. For odd j: x_j = k_{j+5}||k_{j+4} and c_j = k_j||k_{j+1}. Indices are taken mod 8, and the stored carry starts at 0.
- R4: Each iteration sets c_j to c_j + a_j + carry-in mod 2^32. The carry-in of word 0 is the stored carry, and the carry-in of every other word is the carry-out of word j-1. The carry-out of word 7 is stored. The constant a_j is 0x4D34D34D for j in {0,3,6}, 0xD34D34D3 for j in {1,4,7} and 0x34D34D34 for j in {2,5}.
- R5: g(x,c) is the XOR of the high and low 32-bit halves of (x+c)^2, where c is the already-updated counter. For even j the new x_j is g_j + rotl(g_{j-1},16) + rotl(g_{j-2},16). For odd j it is g_j + rotl(g_{j-1},8) + g_{j-2}. Sums are mod 2^32 and indices mod 8.
- R6: After the four warm-up iterations, each c_j is XORed with x_{(j+4) mod 8}.
- R7: When the IV is enabled, with sub-words iv0 = iv[15:0] up to iv3, the counters are XORed as follows, and four more iterations follow:
  - c0 and c4 with iv1||iv0;
  - c1 and c5 with iv3||iv1;
  - c2 and c6 with iv3||iv2;
  - c3 and c7 with iv2||iv0.
- R8: The keystream uses 16-bit lanes s0..s7, with s0 in bits [15:0]:
  - s0 = x0L^x5H and s1 = x0H^x3L;
  - s2 = x2L^x7H and s3 = x2H^x5L;
  - s4 = x4L^x1H and s5 = x4H^x7L;
  - s6 = x6L^x3H and s7 = x6H^x1L.

  The first block comes from one more iteration after setup. `ks_valid_o` is never high while busy.
- R9: While `ks_valid_o` is high and `ks_ready_i` is low, the valid flag and data are held.
- R10: Each accepted block (valid and ready at a clock edge) advances the state by exactly one iteration.
- R11: An accepted load while blocks are being delivered drops valid, raises busy on the next cycle and restarts setup from key expansion with the new key.
- R12: A start pulse while busy or while delivering blocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_valid_i | input | 1 | Key/IV load request |
| load_ready_o | output | 1 | Load can be accepted |
| key_i | input | 128 | Key |
| iv_i | input | 64 | IV |
| iv_use_i | input | 1 | Apply the IV during setup |
| start_i | input | 1 | Begin setup from idle |
| ks_valid_o | output | 1 | Keystream block available |
| ks_ready_i | input | 1 | Consumer takes the block |
| ks_data_o | output | 128 | Keystream block |
| busy_o | output | 1 | Setup in progress |

## Verification
The bench compares every block against its own model of the cipher. Among its keys is an all-ones key, whose counters overflow on the first iteration. A core with a carry chain broken between words, or one that drops the stored carry, therefore diverges within a few blocks. The bench measures the busy window exactly for 7 and 12 cycles, which catches a warm-up loop that is off by one or an IV branch that is skipped. It also holds ready low across several cycles to expose a core that advances without a handshake. Finally, it offers a load and a start during setup and a start during delivery: a core that accepted either would restart setup or emit a different stream.

// File: rtl/kscore_pkg.sv
package kscore_pkg;

    localparam int WORD_W     = 32;
    localparam int N_WORDS    = 8;
    localparam int HALF_W     = WORD_W / 2;
    localparam int KEY_W      = N_WORDS * HALF_W;
    localparam int IV_SUBS    = 4;
    localparam int IV_W       = IV_SUBS * HALF_W;
    localparam int BLOCK_W    = N_WORDS * HALF_W;
    localparam int WARM_ITERS = 4;
    localparam int ITER_W     = (WARM_ITERS > 1) ? $clog2(WARM_ITERS) : 1;
    localparam int ROT_EVEN   = 16;
    localparam int ROT_ODD    = 8;

    typedef logic [N_WORDS-1:0][WORD_W-1:0] wvec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPAND,
        ST_WARM,
        ST_KEYMIX,
        ST_IVMIX,
        ST_IVWARM,
        ST_PRIME,
        ST_RUN
    } state_t;

    // Per-word additive constant, repeating with period three
    function automatic logic [WORD_W-1:0] step_const(input int j);
        case (j % 3)
            0:       return 32'h4D34D34D;
            1:       return 32'hD34D34D3;
            default: return 32'h34D34D34;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    // Square the sum, fold high half onto low half
    function automatic logic [WORD_W-1:0] g_fn(input logic [WORD_W-1:0] x,
                                               input logic [WORD_W-1:0] c);
        logic [WORD_W-1:0]   u;
        logic [2*WORD_W-1:0] sq;
        u  = x + c;
        sq = (2*WORD_W)'(u) * (2*WORD_W)'(u);
        return sq[2*WORD_W-1:WORD_W] ^ sq[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/kscore_ctr_chain.sv
module kscore_ctr_chain
    import kscore_pkg::*;
(
    input  wvec_t c_cur,
    input  logic  carry_in,
    output wvec_t c_nxt,
    output logic  carry_out
);

    logic [N_WORDS:0] cy;
    assign cy[0] = carry_in;

    for (genvar j = 0; j < N_WORDS; j++) begin : g_word
        logic [WORD_W:0] sum;
        assign sum       = {1'b0, c_cur[j]} + {1'b0, step_const(j)} + {{WORD_W{1'b0}}, cy[j]};
        assign c_nxt[j]  = sum[WORD_W-1:0];
        assign cy[j+1]   = sum[WORD_W];
    end

    assign carry_out = cy[N_WORDS];

endmodule

// File: rtl/kscore_state_mix.sv
module kscore_state_mix
    import kscore_pkg::*;
(
    input  wvec_t x_cur,
    input  wvec_t c_nxt,
    output wvec_t x_nxt
);

    wvec_t gv;

    for (genvar j = 0; j < N_WORDS; j++) begin : g_gfun
        assign gv[j] = g_fn(x_cur[j], c_nxt[j]);
    end

    for (genvar j = 0; j < N_WORDS; j++) begin : g_comb
        localparam int JM1 = (j + N_WORDS - 1) % N_WORDS;
        localparam int JM2 = (j + N_WORDS - 2) % N_WORDS;
        if (j % 2 == 0) begin : g_even
            assign x_nxt[j] = gv[j] + rotl(gv[JM1], ROT_EVEN) + rotl(gv[JM2], ROT_EVEN);
        end else begin : g_odd
            assign x_nxt[j] = gv[j] + rotl(gv[JM1], ROT_ODD) + gv[JM2];
        end
    end

endmodule

// File: rtl/kscore_extract.sv
module kscore_extract
    import kscore_pkg::*;
(
    input  wvec_t              x,
    output logic [BLOCK_W-1:0] ks
);

    // Lane pair m uses even word 2m; partners sit five and three words ahead
    for (genvar m = 0; m < N_WORDS / 2; m++) begin : g_lane
        localparam int E  = 2 * m;
        localparam int PH = (E + 5) % N_WORDS;
        localparam int PL = (E + 3) % N_WORDS;
        assign ks[(2*m)*HALF_W   +: HALF_W] = x[E][HALF_W-1:0]      ^ x[PH][WORD_W-1:HALF_W];
        assign ks[(2*m+1)*HALF_W +: HALF_W] = x[E][WORD_W-1:HALF_W] ^ x[PL][HALF_W-1:0];
    end

endmodule

// File: rtl/kscore_top.sv
module kscore_top
    import kscore_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_valid_i,
    output logic               load_ready_o,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [IV_W-1:0]    iv_i,
    input  logic               iv_use_i,
    input  logic               start_i,
    output logic               ks_valid_o,
    input  logic               ks_ready_i,
    output logic [BLOCK_W-1:0] ks_data_o,
    output logic               busy_o
);

    localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(WARM_ITERS - 1);

    state_t             state_q, state_d;
    wvec_t              x_q, c_q;
    logic               carry_q;
    logic [KEY_W-1:0]   key_q;
    logic [IV_W-1:0]    iv_q;
    logic               iv_use_q;
    logic [ITER_W-1:0]  iter_q;

    wvec_t              c_step, x_step, x_init, c_init, c_remix, c_ivmix;
    logic               carry_step;
    logic               load_fire;
    logic               iter_done;

    logic [N_WORDS-1:0][HALF_W-1:0] kw;
    logic [IV_SUBS-1:0][HALF_W-1:0] ivw;

    assign kw  = key_q;
    assign ivw = iv_q;

    // ---------------- iteration datapath ----------------
    kscore_ctr_chain u_ctr (
        .c_cur     (c_q),
        .carry_in  (carry_q),
        .c_nxt     (c_step),
        .carry_out (carry_step)
    );

    kscore_state_mix u_mix (
        .x_cur (x_q),
        .c_nxt (c_step),
        .x_nxt (x_step)
    );

    kscore_extract u_ext (
        .x  (x_q),
        .ks (ks_data_o)
    );

    // ---------------- setup transforms ----------------
    for (genvar j = 0; j < N_WORDS; j++) begin : g_setup
        localparam int P1 = (j + 1) % N_WORDS;
        localparam int P4 = (j + 4) % N_WORDS;
        localparam int P5 = (j + 5) % N_WORDS;
        if (j % 2 == 0) begin : g_even
            assign x_init[j] = {kw[P1], kw[j]};
            assign c_init[j] = {kw[P4], kw[P5]};
        end else begin : g_odd
            assign x_init[j] = {kw[P5], kw[P4]};
            assign c_init[j] = {kw[j], kw[P1]};
        end
        assign c_remix[j] = c_q[j] ^ x_q[P4];

        case (j % IV_SUBS)
            0:       begin : g_iv0 assign c_ivmix[j] = c_q[j] ^ {ivw[1], ivw[0]}; end
            1:       begin : g_iv1 assign c_ivmix[j] = c_q[j] ^ {ivw[3], ivw[1]}; end
            2:       begin : g_iv2 assign c_ivmix[j] = c_q[j] ^ {ivw[3], ivw[2]}; end
            default: begin : g_iv3 assign c_ivmix[j] = c_q[j] ^ {ivw[2], ivw[0]}; end
        endcase
    end

    // ---------------- control ----------------
    assign load_fire = load_valid_i && load_ready_o;
    assign iter_done = (iter_q == ITER_LAST);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)   state_d = ST_EXPAND;
            ST_EXPAND:                state_d = ST_WARM;
            ST_WARM:   if (iter_done) state_d = ST_KEYMIX;
            ST_KEYMIX:                state_d = iv_use_q ? ST_IVMIX : ST_PRIME;
            ST_IVMIX:                 state_d = ST_IVWARM;
            ST_IVWARM: if (iter_done) state_d = ST_PRIME;
            ST_PRIME:                 state_d = ST_RUN;
            ST_RUN:    if (load_fire) state_d = ST_EXPAND;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            x_q      <= '0;
            c_q      <= '0;
            carry_q  <= 1'b0;
            key_q    <= '0;
            iv_q     <= '0;
            iv_use_q <= 1'b0;
            iter_q   <= '0;
        end else begin
            if (load_fire) begin
                key_q    <= key_i;
                iv_q     <= iv_i;
                iv_use_q <= iv_use_i;
            end
            unique case (state_q)
                ST_EXPAND: begin
                    x_q     <= x_init;
                    c_q     <= c_init;
                    carry_q <= 1'b0;
                    iter_q  <= '0;
                end
                ST_WARM, ST_IVWARM: begin
                    x_q     <= x_step;
                    c_q     <= c_step;
                    carry_q <= carry_step;
                    iter_q  <= iter_done ? '0 : iter_q + 1'b1;
                end
                ST_KEYMIX: c_q <= c_remix;
                ST_IVMIX:  c_q <= c_ivmix;
                ST_PRIME: begin
                    x_q     <= x_step;
                    c_q     <= c_step;
                    carry_q <= carry_step;
                end
                ST_RUN: begin
                    if (ks_ready_i && !load_fire) begin
                        x_q     <= x_step;
                        c_q     <= c_step;
                        carry_q <= carry_step;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ks_valid_o   = (state_q == ST_RUN);
        busy_o       = (state_q != ST_RUN) && (state_q != ST_IDLE);
        load_ready_o = !busy_o;
    end

endmodule

// File: rtl/kscore_chk.sv
module kscore_chk
    import kscore_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               load_valid_i,
    input logic               load_ready_o,
    input logic               start_i,
    input logic               ks_valid_o,
    input logic               ks_ready_i,
    input logic [BLOCK_W-1:0] ks_data_o,
    input logic               busy_o
);

    // R9: stalled block is held
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ks_valid_o && !ks_ready_i && !load_valid_i |=> ks_valid_o && $stable(ks_data_o));

    // R8: no block while setup runs
    p_no_valid_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && ks_valid_o));

    // R8: first block only after a setup phase
    p_valid_after_setup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ks_valid_o) |-> $past(busy_o));

    // R2: no load accepted during setup
    p_no_load_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !load_ready_o);

    // R2: start from idle enters setup
    p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o && !ks_valid_o |=> busy_o);

    // R11: load during delivery aborts the stream
    p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ks_valid_o && load_valid_i && load_ready_o |=> busy_o && !ks_valid_o);

    // R12: start during delivery, without load, keeps delivery going
    p_start_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ks_valid_o && start_i && !load_valid_i |=> ks_valid_o);

endmodule

bind kscore_top kscore_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_valid_i (load_valid_i),
    .load_ready_o (load_ready_o),
    .start_i      (start_i),
    .ks_valid_o   (ks_valid_o),
    .ks_ready_i   (ks_ready_i),
    .ks_data_o    (ks_data_o),
    .busy_o       (busy_o)
);

// File: tb/kscore_top_tb.sv
module kscore_top_tb;
    import kscore_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 4;
    localparam int NBLK       = 4;

    localparam logic [127:0] VEC_KEY [NVEC] = '{
        128'h0,
        {128{1'b1}},
        128'h0123456789ABCDEF_FEDCBA9876543210,
        128'h91283746_5A5A0F0F_C3E1B2D4_00FF7E81
    };
    localparam logic [63:0] VEC_IV [NVEC] = '{
        64'h0, 64'h0, 64'h0F1E2D3C_4B5A6978, {64{1'b1}}
    };
    localparam logic VEC_USE [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1};

    localparam logic [31:0] ACONST [8] = '{
        32'h4D34D34D, 32'hD34D34D3, 32'h34D34D34, 32'h4D34D34D,
        32'hD34D34D3, 32'h34D34D34, 32'h4D34D34D, 32'hD34D34D3
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic         load_ready;
    logic [127:0] key = '0;
    logic [63:0]  iv = '0;
    logic         iv_use = 1'b0;
    logic         start = 1'b0;
    logic         ks_valid;
    logic         ks_ready = 1'b0;
    logic [127:0] ks_data;
    logic         busy;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mx [8];
    logic [31:0] mc [8];
    logic        mcar;

    always #(CLK_PERIOD/2) clk = ~clk;

    kscore_top u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_valid_i (load_valid),
        .load_ready_o (load_ready),
        .key_i        (key),
        .iv_i         (iv),
        .iv_use_i     (iv_use),
        .start_i      (start),
        .ks_valid_o   (ks_valid),
        .ks_ready_i   (ks_ready),
        .ks_data_o    (ks_data),
        .busy_o       (busy)
    );

    // ---------------- reference model ----------------
    function automatic logic [31:0] m_rol(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [31:0] m_g(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] u;
        logic [63:0] sq;
        u  = a + b;
        sq = {32'h0, u} * {32'h0, u};
        return sq[63:32] ^ sq[31:0];
    endfunction

    task automatic m_iter();
        logic [32:0] s;
        logic [31:0] gg [8];
        logic        car;
        car = mcar;
        for (int j = 0; j < 8; j++) begin
            s     = {1'b0, mc[j]} + {1'b0, ACONST[j]} + {32'h0, car};
            mc[j] = s[31:0];
            car   = s[32];
        end
        mcar = car;
        for (int j = 0; j < 8; j++) gg[j] = m_g(mx[j], mc[j]);
        for (int j = 0; j < 8; j++) begin
            if (j % 2 == 0)
                mx[j] = gg[j] + m_rol(gg[(j+7)%8], 16) + m_rol(gg[(j+6)%8], 16);
            else
                mx[j] = gg[j] + m_rol(gg[(j+7)%8], 8) + gg[(j+6)%8];
        end
    endtask

    task automatic m_setup(input logic [127:0] k_in, input logic [63:0] v_in, input logic use_iv);
        logic [15:0] k [8];
        logic [15:0] i0, i1, i2, i3;
        for (int j = 0; j < 8; j++) k[j] = k_in[16*j +: 16];
        for (int j = 0; j < 8; j++) begin
            if (j % 2 == 0) begin
                mx[j] = {k[(j+1)%8], k[j]};
                mc[j] = {k[(j+4)%8], k[(j+5)%8]};
            end else begin
                mx[j] = {k[(j+5)%8], k[(j+4)%8]};
                mc[j] = {k[j], k[(j+1)%8]};
            end
        end
        mcar = 1'b0;
        for (int r = 0; r < 4; r++) m_iter();
        for (int j = 0; j < 8; j++) mc[j] = mc[j] ^ mx[(j+4)%8];
        if (use_iv) begin
            i0 = v_in[15:0]; i1 = v_in[31:16]; i2 = v_in[47:32]; i3 = v_in[63:48];
            mc[0] ^= {i1, i0}; mc[4] ^= {i1, i0};
            mc[1] ^= {i3, i1}; mc[5] ^= {i3, i1};
            mc[2] ^= {i3, i2}; mc[6] ^= {i3, i2};
            mc[3] ^= {i2, i0}; mc[7] ^= {i2, i0};
            for (int r = 0; r < 4; r++) m_iter();
        end
        m_iter();
    endtask

    function automatic logic [127:0] m_block();
        return {mx[6][31:16] ^ mx[1][15:0],  mx[6][15:0] ^ mx[3][31:16],
                mx[4][31:16] ^ mx[7][15:0],  mx[4][15:0] ^ mx[1][31:16],
                mx[2][31:16] ^ mx[5][15:0],  mx[2][15:0] ^ mx[7][31:16],
                mx[0][31:16] ^ mx[3][15:0],  mx[0][15:0] ^ mx[5][31:16]};
    endfunction

    // ---------------- helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic count_busy(output int n, output int vbad);
        n = 0;
        vbad = 0;
        while (busy && n < 100) begin
            if (ks_valid || load_ready) vbad++;
            n++;
            tick();
        end
    endtask

    task automatic load_and_start(input logic [127:0] k, input logic [63:0] v, input logic u);
        key = k; iv = v; iv_use = u;
        load_valid = 1'b1; start = 1'b1;
        tick();
        load_valid = 1'b0; start = 1'b0;
    endtask

    task automatic advance();
        ks_ready = 1'b1;
        tick();
        ks_ready = 1'b0;
        m_iter();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int nb, vb;
        logic [127:0] held;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk(ks_valid, 1'b0, "R1 valid after reset");
        chk(busy, 1'b0, "R1 busy after reset");
        chk(load_ready, 1'b1, "R1 load_ready after reset");

        // Vector table: R3 R4 R5 R6 R7 R8 R10, R11 (reload while running)
        for (int v = 0; v < NVEC; v++) begin
            load_and_start(VEC_KEY[v], VEC_IV[v], VEC_USE[v]);
            count_busy(nb, vb);
            chk(nb, VEC_USE[v] ? 12 : 7, "R2/R7 setup length");
            chk(vb, 0, "R2/R8 valid or load_ready during setup");
            m_setup(VEC_KEY[v], VEC_IV[v], VEC_USE[v]);
            for (int b = 0; b < NBLK; b++) begin
                chk(ks_valid, 1'b1, "R8 valid in delivery");
                chk(ks_data, m_block(), "R3/R4/R5/R6/R7/R8/R10 block");
                if (b == 1) begin
                    held = ks_data;
                    for (int h = 0; h < 3; h++) begin
                        tick();
                        chk(ks_valid, 1'b1, "R9 valid held");
                        chk(ks_data, held, "R9 data held");
                    end
                end
                advance();
            end
        end

        // R12: start while delivering is ignored
        held = ks_data;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(ks_valid, 1'b1, "R12 valid after start in delivery");
        chk(busy, 1'b0, "R12 busy after start in delivery");
        chk(ks_data, held, "R12 data after start in delivery");
        advance();
        chk(ks_data, m_block(), "R12 stream continues");

        // R11: abort with a fresh key, no IV
        key = 128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F;
        iv_use = 1'b0;
        load_valid = 1'b1;
        tick();
        load_valid = 1'b0;
        chk(busy, 1'b1, "R11 busy after abort");
        chk(ks_valid, 1'b0, "R11 valid after abort");
        count_busy(nb, vb);
        chk(nb, 7, "R11 setup length after abort");
        m_setup(128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F, 64'h0, 1'b0);
        chk(ks_data, m_block(), "R11 stream after abort");

        // R2/R12: load and start offered in mid-setup are ignored
        load_and_start(128'h1111_2222_3333_4444_5555_6666_7777_8888, 64'h0, 1'b0);
        tick();
        tick();
        chk(load_ready, 1'b0, "R2 load_ready low during setup");
        key = 128'hDEAD_BEEF_0000_0000_0000_0000_0000_0001;
        iv_use = 1'b1;
        load_valid = 1'b1;
        start = 1'b1;
        tick();
        load_valid = 1'b0;
        start = 1'b0;
        count_busy(nb, vb);
        chk(nb, 4, "R12 remaining setup after mid-setup start");
        m_setup(128'h1111_2222_3333_4444_5555_6666_7777_8888, 64'h0, 1'b0);
        chk(ks_data, m_block(), "R2 mid-setup load ignored");
        advance();
        chk(ks_data, m_block(), "R10 next block after mid-setup test");

        // R1: reset in mid-stream returns to idle
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk(ks_valid, 1'b0, "R1 valid after mid-stream reset");
        chk(busy, 1'b0, "R1 busy after mid-stream reset");

        summary();
    end

endmodule